// File: doc/BRIEF.md
# Accumulator ALU With Flags

This unit is the arithmetic and logic stage of a small accumulator machine. The accumulator value arrives on `acc_in` and acts as the first operand. The second operand arrives on `opb_in`; the surrounding datapath takes it from any of the data registers. A 3-bit code on `op_sel` picks one of seven operations. On a clock edge where `step_en` is high, the unit registers the new accumulator value on `acc_out` and rewrites all three flags: zero, negative and carry.

The stored carry flag is fed back into the carry-in and borrow-in operations. Because of this, a run of byte-wide add or subtract steps can work on numbers that are several bytes wide, starting from the least significant byte. The register file and the instruction decode sit outside this unit.

Operands are presented as plain levels together with a single strobe. The unit accepts a new operation on every cycle that the strobe is high. It never applies back-pressure, so the unit has no ready output.

Top module: `acc_alu_unit`

## Requirements
- R1: Op code 0 (add) with `step_en` high registers `acc_in + opb_in` modulo 256 on `acc_out`. Carry is set when the true sum is above 255.
- R2: Op code 1 (subtract) registers `acc_in - opb_in` modulo 256. Carry acts as a borrow: it is set exactly when `opb_in` is greater than `acc_in` as unsigned values.
- R3: Op code 2 (add with carry) registers `acc_in + opb_in + C`, where C is the carry flag held before the edge. Carry is set when this sum is above 255.
- R4: Op code 3 (subtract with borrow) registers `acc_in - opb_in - C`. Carry is set exactly when `opb_in + C` is greater than `acc_in`.
- R5: Op code 4 registers the bitwise AND of the operands and op code 5 registers the bitwise OR. Both clear carry.
- R6: Op code 6 registers the bitwise inverse of `acc_in` and clears carry. The value on `opb_in` has no effect on the result or the flags.
- R7: After every operation with codes 0 to 6, the zero flag is 1 exactly when the registered 8-bit result is 0.
- R8: After every operation with codes 0 to 6, the negative flag equals bit 7 of the registered result.
- R9: While `step_en` is low, `acc_out` and the flags hold their values, whatever the other inputs do.
- R10: Op code 7 is reserved. With `step_en` high it changes neither `acc_out` nor any flag.
- R11: Asynchronous active-low reset clears `acc_out` and all three flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Strobe: perform the selected operation at this edge |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 adc, 3 sbb, 4 and, 5 or, 6 not, 7 reserved) |
| acc_in | input | W (8) | Current accumulator, first operand |
| opb_in | input | W (8) | Second operand |
| acc_out | output | W (8) | Registered new accumulator value |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
The hard case is a carry-consuming operation that reads the stored carry and rewrites it at the same edge. The flag is both an input to the adder and an output of that same step.

The bench provokes this case in two ways:
- Before each add-with-carry and subtract-with-borrow step, it loads the carry to a known value with a preceding add, for both carry values, across a sweep of all accumulator values.
- It runs two-byte add and subtract chains in which each step consumes the carry that the previous step produced.

Each result and flag set is judged against an arithmetic model in the bench. That model carries its own copy of the flag from step to step.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADC  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_NOT  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
  } alu_flags_t;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADC) || (op == OP_SBB);
  endfunction

  function automatic logic op_is_sub(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBB);
  endfunction

  function automatic logic op_uses_carry(alu_op_e op);
    return (op == OP_ADC) || (op == OP_SBB);
  endfunction

endpackage

// File: rtl/alu_arith.sv
// Single shared adder for all four arithmetic codes.
// Subtraction is done as a + ~b + 1, and borrow is the inverted carry-out.
module alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_stored,
  output logic [W-1:0] res,
  output logic         c_out
);
  localparam int SW = W + 1;

  logic          sub_m;
  logic          chain_c;
  logic          ci;
  logic [W-1:0]  b_eff;
  logic [SW-1:0] sum;

  always_comb begin
    sub_m   = op_is_sub(op);
    chain_c = op_uses_carry(op) & c_stored;
    b_eff   = sub_m ? ~b : b;
    // For subtraction, a stored borrow removes the +1 of two's complement.
    ci      = sub_m ? ~chain_c : chain_c;
    sum     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci};
    res     = sum[W-1:0];
    c_out   = sub_m ? ~sum[W] : sum[W];
  end

endmodule

// File: rtl/alu_logic.sv
// Bitwise slice for AND / OR / NOT, built one bit at a time.
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (op)
        OP_AND:  res[i] = a[i] & b[i];
        OP_OR:   res[i] = a[i] | b[i];
        OP_NOT:  res[i] = ~a[i];
        default: res[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/alu_flag_gen.sv
// Derives the next flag set from a result.
// Carry survives only for arithmetic codes; logic codes clear it.
module alu_flag_gen
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  input  logic         c_arith,
  input  logic         arith_sel,
  output alu_flags_t   flags
);
  always_comb begin
    flags.z = ~|res;
    flags.n = res[W-1];
    flags.c = arith_sel & c_arith;
  end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opb_in,
  output logic [W-1:0] acc_out,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_c
);
  alu_op_e      op;
  logic [W-1:0] ar_res;
  logic         ar_c;
  logic [W-1:0] lg_res;
  logic         ar_sel;
  logic [W-1:0] nxt_res;
  alu_flags_t   nxt_flags;
  alu_flags_t   flags_q;
  logic [W-1:0] acc_q;
  logic         commit;

  assign op = alu_op_e'(op_sel);

  alu_arith #(.W(W)) u_arith (
    .op       (op),
    .a        (acc_in),
    .b        (opb_in),
    .c_stored (flags_q.c),
    .res      (ar_res),
    .c_out    (ar_c)
  );

  alu_logic #(.W(W)) u_logic (
    .op  (op),
    .a   (acc_in),
    .b   (opb_in),
    .res (lg_res)
  );

  always_comb begin
    ar_sel  = op_is_arith(op);
    nxt_res = ar_sel ? ar_res : lg_res;
    commit  = step_en && (op != OP_NONE);
  end

  alu_flag_gen #(.W(W)) u_flags (
    .res       (nxt_res),
    .c_arith   (ar_c),
    .arith_sel (ar_sel),
    .flags     (nxt_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (commit) begin
      acc_q   <= nxt_res;
      flags_q <= nxt_flags;
    end
  end

  assign acc_out = acc_q;
  assign flag_z  = flags_q.z;
  assign flag_n  = flags_q.n;
  assign flag_c  = flags_q.c;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_en,
  input logic [2:0]   op_sel,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] opb_in,
  input logic [W-1:0] acc_out,
  input logic         flag_z,
  input logic         flag_n,
  input logic         flag_c
);
  logic [2:0] flg;
  assign flg = {flag_z, flag_n, flag_c};

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_sel == 3'd0) |=>
      ({flag_c, acc_out} == ({1'b0, $past(acc_in)} + {1'b0, $past(opb_in)})));

  // R6
  not_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_sel == 3'd6) |=> (acc_out == ~$past(acc_in)) && !flag_c);

  // R5
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (op_sel == 3'd4 || op_sel == 3'd5)) |=> !flag_c);

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_sel != 3'd7) |=> (flag_z == (acc_out == '0)));

  // R8
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_sel != 3'd7) |=> (flag_n == acc_out[W-1]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(acc_out) && $stable(flg));

  // R10
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_sel == 3'd7) |=> $stable(acc_out) && $stable(flg));

endmodule

bind acc_alu_unit acc_alu_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .step_en (step_en),
  .op_sel  (op_sel),
  .acc_in  (acc_in),
  .opb_in  (opb_in),
  .acc_out (acc_out),
  .flag_z  (flag_z),
  .flag_n  (flag_n),
  .flag_c  (flag_c)
);

// File: tb/acc_alu_unit_test.sv
module acc_alu_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] acc_in = 8'd0;
  logic [7:0] opb_in = 8'd0;
  logic [7:0] acc_out;
  logic       flag_z, flag_n, flag_c;

  int total = 0;
  int bad = 0;
  // bench model state
  logic [7:0] m_acc = 8'd0;
  logic       m_z = 1'b0, m_n = 1'b0, m_c = 1'b0;

  always #5 clk = ~clk;

  acc_alu_unit #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .op_sel(op_sel),
    .acc_in(acc_in), .opb_in(opb_in), .acc_out(acc_out),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
  );

  task automatic check_state(input string tag);
    total++;
    if ({acc_out, flag_z, flag_n, flag_c} !== {m_acc, m_z, m_n, m_c}) begin
      bad++;
      $display("FAIL %s: acc=%02h znc=%b%b%b expected acc=%02h znc=%b%b%b",
               tag, acc_out, flag_z, flag_n, flag_c, m_acc, m_z, m_n, m_c);
    end
  endtask

  task automatic model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    int ai = a, bi = b, ci = m_c, r;
    logic c;
    case (op)
      3'd0: begin r = ai + bi;      c = (r > 255);       end // R1
      3'd1: begin r = ai - bi;      c = (bi > ai);       end // R2
      3'd2: begin r = ai + bi + ci; c = (r > 255);       end // R3
      3'd3: begin r = ai - bi - ci; c = (bi + ci > ai);  end // R4
      3'd4: begin r = ai & bi;      c = 1'b0;            end // R5
      3'd5: begin r = ai | bi;      c = 1'b0;            end // R5
      3'd6: begin r = (~ai) & 255;  c = 1'b0;            end // R6
      default: return;                                      // R10
    endcase
    m_acc = r[7:0];
    m_z = (m_acc == 8'd0); // R7
    m_n = m_acc[7];        // R8
    m_c = c;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] a,
                        input logic [7:0] b, input string tag);
    @(negedge clk);
    op_sel = op; acc_in = a; opb_in = b; step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    model(op, a, b);
    check_state(tag);
  endtask

  initial begin
    #(1_900_000);
    bad++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] bvals [12] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h55, 8'h7F,
                               8'h80, 8'h81, 8'hAA, 8'hF0, 8'hFE, 8'hFF};
    repeat (3) @(negedge clk);
    check_state("R11 reset");
    rst_n = 1'b1;

    // two-byte chains: 0x12FF + 0x0101 = 0x1400, then 0x1400 - 0x0001 = 0x13FF
    run_op(3'd0, 8'hFF, 8'h01, "R1 chain low");
    run_op(3'd2, 8'h12, 8'h01, "R3 chain high");
    run_op(3'd1, 8'h00, 8'h01, "R2 chain low");
    run_op(3'd3, 8'h14, 8'h00, "R4 chain high");

    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 12; bi++) begin
        logic [7:0] a = ai[7:0];
        logic [7:0] b = bvals[bi];
        run_op(3'd0, a, b, "R1 add");
        run_op(3'd1, a, b, "R2 sub");
        for (int cv = 0; cv < 2; cv++) begin
          run_op(3'd0, 8'hFF, cv[7:0], "R1 carry preset");
          run_op(3'd2, a, b, "R3 adc");
          run_op(3'd0, 8'hFF, cv[7:0], "R1 carry preset");
          run_op(3'd3, a, b, "R4 sbb");
        end
        run_op(3'd4, a, b, "R5 and");
        run_op(3'd5, a, b, "R5 or");
        run_op(3'd6, a, b, "R6 not");
        if (bi == 0) begin
          // R9: new inputs with strobe low must not disturb the state
          @(negedge clk);
          op_sel = 3'd0; acc_in = ~a; opb_in = 8'h5A; step_en = 1'b0;
          @(negedge clk);
          check_state("R9 idle hold");
          // R10: reserved code with strobe high
          run_op(3'd7, ~a, 8'h33, "R10 reserved");
        end
      end
    end

    // R6: operand b has no effect on NOT
    run_op(3'd6, 8'h3C, 8'h00, "R6 not b=00");
    run_op(3'd6, 8'h3C, 8'hFF, "R6 not b=FF");

    // R11: reset in the middle of a run clears everything
    run_op(3'd0, 8'hF0, 8'hF0, "R1 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    m_acc = 8'd0; m_z = 1'b0; m_n = 1'b0; m_c = 1'b0;
    @(negedge clk);
    check_state("R11 mid reset");
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule